// File: doc/BRIEF.md
# Serial Receiver with Selectable Sample Point

This block turns an asynchronous serial line into characters. It runs on the system clock, counts a 16x baud tick, and splits each bit period into sixteen sub-positions. A 4-bit sample-point register selects the sub-position at which every bit of the frame is taken. Setting it early or late compensates for cables and line drivers that distort the rise and fall times.

The raw line can be inverted before it reaches the synchroniser. The whole receiver can be switched off. An optional half-duplex mode holds it idle while the local transmitter drives the shared line. The frame carries 5 to 8 data bits, sent LSB first, and an optional even or odd parity bit. Each character appears on a one-clock valid strobe, together with parity-error, framing-error and break flags. When the drop option is on, a character with a parity or framing error is removed before the strobe. The FIFO, interrupts and baud generation sit outside this block.

Top module: `serial_rx_sampler`

## Requirements
- R1: Counting the tick on which a low line is first seen in the hunt state as tick 0, frame bit k (k=0 start, then data, then parity if enabled, then stop) is sampled on tick 16k+P, where P is the sample-point register.
- R2: The sample-point register resets to 7 and takes `sp_value` on any clock with `sp_load` high.
- R3: If the line is high when the start bit is sampled, the frame is abandoned, no character is produced and the receiver hunts again. With P=0 the start is accepted on tick 0.
- R4: With `cfg_invert` high the receiver behaves exactly as if the line were driven with the complemented level.
- R5: `cfg_data_bits` values 0,1,2,3 select 5,6,7,8 data bits. The first data bit received is bit 0 of `rx_data`, and bits above the selected count read 0.
- R6: With parity enabled, `rx_parity_err` is set when the XOR of the data bits and the parity bit is not 0 for even parity (`cfg_parity_even`=1) or not 1 for odd parity. Without parity it stays 0.
- R7: A low stop sample sets `rx_frame_err`. The receiver then waits for a high line before it hunts for a new start.
- R8: `rx_break` is set when all data bits, the parity bit if present, and the stop bit were sampled low.
- R9: While `cfg_rx_off` is high no character is produced, and any frame in progress is abandoned.
- R10: While `cfg_hold_on_tx` and `tx_active` are both high the receiver is held in the hunt state exactly as in R9. With `cfg_hold_on_tx` low, `tx_active` has no effect.
- R11: With `cfg_drop_err` high, a character with a parity or framing error produces no strobe. Error-free characters are still delivered.
- R12: `rx_valid` is a one-clock pulse on the clock after the tick that carries the stop sample. The flags are 0 whenever `rx_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Raw serial input |
| tick16 | input | 1 | One-clock pulse at 16 times the baud rate |
| sp_load | input | 1 | Load strobe for the sample-point register |
| sp_value | input | 4 | New sample point, 0 start of bit to 15 end |
| cfg_invert | input | 1 | Invert the raw line |
| cfg_rx_off | input | 1 | Disable the receiver |
| cfg_hold_on_tx | input | 1 | Enable half-duplex gating |
| tx_active | input | 1 | Local transmitter busy |
| cfg_data_bits | input | 2 | Data length, 0..3 for 5..8 bits |
| cfg_parity_en | input | 1 | Parity bit present |
| cfg_parity_even | input | 1 | 1 even, 0 odd parity |
| cfg_drop_err | input | 1 | Discard characters with errors |
| rx_data | output | 8 | Received character |
| rx_valid | output | 1 | Character strobe |
| rx_parity_err | output | 1 | Parity error flag |
| rx_frame_err | output | 1 | Framing error flag |
| rx_break | output | 1 | Break flag |

## Verification
The hardest situation to reach from the ports is a start pulse too short to pass validation at one sample point but long enough at another. The bench drives the line one tick slot at a time, so it can shape a low pulse a few ticks long and replay it at several sample points. A second hard case is a frame that is interrupted part way by the disable or half-duplex gate and then followed by a clean frame. The bench builds this from partial frames that switch the gating between tick slots. A reference model steps per tick and checks the strobe position and contents on every clock.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_FRAME  = 2'd1,
    ST_WAIT_HI = 2'd2
  } rx_state_e;

  typedef struct packed {
    logic [7:0] data;
    logic       perr;
    logic       ferr;
    logic       brk;
  } rx_char_t;

endpackage

// File: rtl/rxs_line_sync.sv
module rxs_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  input  logic invert,
  output logic line_out
);
  logic [STAGES-1:0] chain_q;

  // inversion precedes synchronisation; idle level after reset is high
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b1;
          else        chain_q[0] <= raw_in ^ invert;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b1;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign line_out = chain_q[STAGES-1];
endmodule

// File: rtl/rxs_frame_fsm.sv
module rxs_frame_fsm
  import rxs_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int OVS_BITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                line,
  input  logic                gate,
  input  logic [OVS_BITS-1:0] pos,
  input  logic [1:0]          len_sel,
  input  logic                par_en,
  input  logic                par_even,
  output logic                done,
  output rx_char_t            char_o
);
  localparam int MIN_BITS = DATA_W - 3;
  localparam int IDX_W    = $clog2(DATA_W + 3);

  rx_state_e            st_q, st_d;
  logic [OVS_BITS-1:0]  sub_q, sub_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic [DATA_W-1:0]    data_q, data_d;
  logic                 pbit_q, pbit_d;
  logic [IDX_W-1:0]     nbits, par_idx;

  assign nbits   = IDX_W'(MIN_BITS) + IDX_W'(len_sel);
  assign par_idx = nbits + IDX_W'(1);

  always_comb begin
    st_d   = st_q;
    sub_d  = sub_q;
    idx_d  = idx_q;
    data_d = data_q;
    pbit_d = pbit_q;
    done   = 1'b0;
    char_o.data = 8'(data_q);
    char_o.ferr = ~line;
    char_o.perr = par_en & ((^data_q) ^ pbit_q ^ ~par_even);
    char_o.brk  = ~line & (data_q == '0) & ~(par_en & pbit_q);
    if (gate) begin
      st_d = ST_HUNT;
    end else if (tick) begin
      unique case (st_q)
        ST_HUNT: begin
          if (!line) begin
            st_d   = ST_FRAME;
            sub_d  = OVS_BITS'(1);
            idx_d  = '0;
            data_d = '0;
            pbit_d = 1'b0;
          end
        end
        ST_FRAME: begin
          sub_d = sub_q + OVS_BITS'(1);
          if (sub_q == '1) idx_d = idx_q + IDX_W'(1);
          if (sub_q == pos) begin
            if (idx_q == '0) begin
              if (line) st_d = ST_HUNT;
            end else if (idx_q <= nbits) begin
              for (int i = 0; i < DATA_W; i++) begin
                if (idx_q == IDX_W'(i + 1)) data_d[i] = line;
              end
            end else if (par_en && idx_q == par_idx) begin
              pbit_d = line;
            end else begin
              done = 1'b1;
              st_d = line ? ST_HUNT : ST_WAIT_HI;
            end
          end
        end
        ST_WAIT_HI: begin
          if (line) st_d = ST_HUNT;
        end
        default: st_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HUNT;
      sub_q  <= '0;
      idx_q  <= '0;
      data_q <= '0;
      pbit_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      sub_q  <= sub_d;
      idx_q  <= idx_d;
      data_q <= data_d;
      pbit_q <= pbit_d;
    end
  end
endmodule

// File: rtl/rxs_out_stage.sv
module rxs_out_stage
  import rxs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     done,
  input  rx_char_t char_i,
  input  logic     drop_err,
  output logic     valid_o,
  output rx_char_t char_o
);
  logic     keep;
  logic     valid_d;
  rx_char_t char_d;

  always_comb begin
    keep    = ~(drop_err & (char_i.perr | char_i.ferr));
    valid_d = done & keep;
    char_d  = valid_d ? char_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      char_o  <= '0;
    end else begin
      valid_o <= valid_d;
      char_o  <= char_d;
    end
  end
endmodule

// File: rtl/serial_rx_sampler.sv
module serial_rx_sampler
  import rxs_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVS_BITS    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int SAMPLE_RST  = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_line,
  input  logic                tick16,
  input  logic                sp_load,
  input  logic [OVS_BITS-1:0] sp_value,
  input  logic                cfg_invert,
  input  logic                cfg_rx_off,
  input  logic                cfg_hold_on_tx,
  input  logic                tx_active,
  input  logic [1:0]          cfg_data_bits,
  input  logic                cfg_parity_en,
  input  logic                cfg_parity_even,
  input  logic                cfg_drop_err,
  output logic [7:0]          rx_data,
  output logic                rx_valid,
  output logic                rx_parity_err,
  output logic                rx_frame_err,
  output logic                rx_break
);
  logic [OVS_BITS-1:0] pos_q, pos_d;
  logic                line_s;
  logic                gate;
  logic                done;
  rx_char_t            char_raw, char_out;

  always_comb begin
    pos_d = pos_q;
    if (sp_load) pos_d = sp_value;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= OVS_BITS'(SAMPLE_RST);
    else        pos_q <= pos_d;
  end

  assign gate = cfg_rx_off | (cfg_hold_on_tx & tx_active);

  rxs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_in   (rx_line),
    .invert   (cfg_invert),
    .line_out (line_s)
  );

  rxs_frame_fsm #(.DATA_W(DATA_W), .OVS_BITS(OVS_BITS)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick16),
    .line     (line_s),
    .gate     (gate),
    .pos      (pos_q),
    .len_sel  (cfg_data_bits),
    .par_en   (cfg_parity_en),
    .par_even (cfg_parity_even),
    .done     (done),
    .char_o   (char_raw)
  );

  rxs_out_stage u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (done),
    .char_i   (char_raw),
    .drop_err (cfg_drop_err),
    .valid_o  (rx_valid),
    .char_o   (char_out)
  );

  assign rx_data       = char_out.data;
  assign rx_parity_err = char_out.perr;
  assign rx_frame_err  = char_out.ferr;
  assign rx_break      = char_out.brk;
endmodule

// File: rtl/serial_rx_sampler_chk.sv
module serial_rx_sampler_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_rx_off,
  input logic cfg_hold_on_tx,
  input logic tx_active,
  input logic cfg_parity_en,
  input logic cfg_drop_err,
  input logic rx_valid,
  input logic rx_parity_err,
  input logic rx_frame_err,
  input logic rx_break
);
  a_r12_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r12_flags_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> !(rx_parity_err || rx_frame_err || rx_break));

  a_r8_break_framing: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_break) |-> rx_frame_err);

  a_r9_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rx_off |=> !rx_valid);

  a_r10_hold_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_hold_on_tx && tx_active) |=> !rx_valid);

  a_r11_drop_clean: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_drop_err |=> !(rx_parity_err || rx_frame_err));

  a_r6_no_parity_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_parity_en |=> !rx_parity_err);
endmodule

bind serial_rx_sampler serial_rx_sampler_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_rx_off     (cfg_rx_off),
  .cfg_hold_on_tx (cfg_hold_on_tx),
  .tx_active      (tx_active),
  .cfg_parity_en  (cfg_parity_en),
  .cfg_drop_err   (cfg_drop_err),
  .rx_valid       (rx_valid),
  .rx_parity_err  (rx_parity_err),
  .rx_frame_err   (rx_frame_err),
  .rx_break       (rx_break)
);

// File: tb/serial_rx_sampler_tb.sv
module serial_rx_sampler_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_line, tick16, sp_load;
  logic [3:0] sp_value;
  logic       cfg_invert, cfg_rx_off, cfg_hold_on_tx, tx_active;
  logic [1:0] cfg_data_bits;
  logic       cfg_parity_en, cfg_parity_even, cfg_drop_err;
  logic [7:0] rx_data;
  logic       rx_valid, rx_parity_err, rx_frame_err, rx_break;

  int n_checks = 0;
  int n_fail   = 0;
  string req = "R12";

  // reference model state
  int         m_st = 0;   // 0 hunt, 1 in frame, 2 wait for high
  int         m_t  = 0;
  int         m_pos = 7;
  logic [7:0] m_d;
  logic       m_p;
  bit         e_v = 0;
  logic [7:0] e_d;
  bit         e_pe, e_fe, e_br;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_rx_sampler u_dut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .tick16(tick16),
    .sp_load(sp_load), .sp_value(sp_value), .cfg_invert(cfg_invert),
    .cfg_rx_off(cfg_rx_off), .cfg_hold_on_tx(cfg_hold_on_tx),
    .tx_active(tx_active), .cfg_data_bits(cfg_data_bits),
    .cfg_parity_en(cfg_parity_en), .cfg_parity_even(cfg_parity_even),
    .cfg_drop_err(cfg_drop_err), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err),
    .rx_break(rx_break)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung run, expected completion");
    summary();
    $finish;
  end

  task automatic check_outputs();
    n_checks++;
    if (rx_valid !== e_v) begin
      n_fail++;
      $display("FAIL %s valid: actual %0b expected %0b", req, rx_valid, e_v);
    end else if (e_v) begin
      if ({rx_data, rx_parity_err, rx_frame_err, rx_break} !== {e_d, e_pe, e_fe, e_br}) begin
        n_fail++;
        $display("FAIL %s char: actual %h/%b%b%b expected %h/%b%b%b", req,
                 rx_data, rx_parity_err, rx_frame_err, rx_break, e_d, e_pe, e_fe, e_br);
      end
    end else if (rx_parity_err || rx_frame_err || rx_break) begin
      n_fail++;
      $display("FAIL R12 flags: actual %b%b%b expected 000", rx_parity_err, rx_frame_err, rx_break);
    end
    e_v = 0;
  endtask

  task automatic model_tick(bit l);
    int  nb, k;
    bit  pe;
    nb = 5 + int'(cfg_data_bits);
    if (cfg_rx_off || (cfg_hold_on_tx && tx_active)) begin
      m_st = 0;
    end else if (m_st == 0) begin
      if (!l) begin m_st = 1; m_t = 1; m_d = '0; m_p = 1'b0; end
    end else if (m_st == 2) begin
      if (l) m_st = 0;
    end else begin
      k = m_t / 16;
      if (m_t % 16 == m_pos) begin
        if (k == 0) begin
          if (l) m_st = 0;
        end else if (k <= nb) begin
          m_d[k-1] = l;
        end else if (cfg_parity_en && k == nb + 1) begin
          m_p = l;
        end else begin
          pe = cfg_parity_en && ((^m_d ^ m_p) != !cfg_parity_even);
          if (!(cfg_drop_err && (pe || !l))) begin
            e_v = 1; e_d = m_d; e_pe = pe; e_fe = !l;
            e_br = !l && m_d == 0 && !(cfg_parity_en && m_p);
          end
          m_st = l ? 0 : 2;
        end
      end
      m_t++;
    end
  endtask

  task automatic slot(bit v);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check_outputs();
      rx_line = v ^ cfg_invert;
      tick16  = (c == 3);
      if (c == 3) model_tick(v);
    end
  endtask

  task automatic push(bit v, int n);
    for (int i = 0; i < n; i++) slot(v);
  endtask

  task automatic set_pos(int p);
    @(negedge clk);
    check_outputs();
    tick16 = 0; sp_load = 1; sp_value = 4'(p);
    m_pos = p;
    @(negedge clk);
    check_outputs();
    sp_load = 0;
  endtask

  task automatic set_invert(bit inv);
    @(negedge clk);
    check_outputs();
    tick16 = 0;
    cfg_invert = inv;
    rx_line = 1'b1 ^ inv;
  endtask

  // frame with optional corrupted parity and chosen stop level
  task automatic send(logic [7:0] d, bit bad_par, bit stop_v);
    int  nb;
    bit  pb;
    nb = 5 + int'(cfg_data_bits);
    pb = 1'b0;
    for (int i = 0; i < nb; i++) pb ^= d[i];
    if (!cfg_parity_even) pb = ~pb;
    if (bad_par) pb = ~pb;
    push(0, 16);
    for (int i = 0; i < nb; i++) push(d[i], 16);
    if (cfg_parity_en) push(pb, 16);
    push(stop_v, 16);
    push(1, 20);
  endtask

  initial begin
    rst_n = 0; rx_line = 1; tick16 = 0; sp_load = 0; sp_value = 0;
    cfg_invert = 0; cfg_rx_off = 0; cfg_hold_on_tx = 0; tx_active = 0;
    cfg_data_bits = 2'd3; cfg_parity_en = 0; cfg_parity_even = 1; cfg_drop_err = 0;
    req = "R12 reset";
    repeat (3) begin @(negedge clk); check_outputs(); end
    rst_n = 1;
    push(1, 4);

    req = "R2 default point";         send(8'hA5, 0, 1);
    req = "R1 8N1";                   send(8'h3C, 0, 1);
    req = "R1 point 0"; set_pos(0);   send(8'h96, 0, 1);
    req = "R1 point 15"; set_pos(15); send(8'h4B, 0, 1);
    req = "R5 seven bits"; cfg_data_bits = 2'd2; send(8'h55, 0, 1);
    req = "R5 five bits";  cfg_data_bits = 2'd0; set_pos(7); send(8'hFB, 0, 1);
    cfg_data_bits = 2'd3;
    req = "R6 even ok";  cfg_parity_en = 1; send(8'h71, 0, 1);
    req = "R6 even bad";                    send(8'h71, 1, 1);
    req = "R6 odd ok";   cfg_parity_even = 0; send(8'hC3, 0, 1);
    req = "R6 odd bad";                       send(8'h0E, 1, 1);
    cfg_parity_en = 0; cfg_parity_even = 1;

    req = "R3 short start rejected"; push(0, 4); push(1, 200);
    req = "R3 short start accepted"; set_pos(2); push(0, 4); push(1, 200);
    set_pos(7);

    req = "R4 inverted"; set_invert(1); send(8'h5A, 0, 1); set_invert(0);

    req = "R7 framing"; send(8'h81, 0, 0);
    req = "R7 wait high"; push(0, 40); push(1, 20);
    req = "R8 break"; push(0, 200); push(1, 20);
    req = "R8 break parity"; cfg_parity_en = 1; push(0, 200); push(1, 20);
    cfg_parity_en = 0;

    req = "R11 drop framing"; cfg_drop_err = 1; send(8'h42, 0, 0);
    req = "R11 drop parity"; cfg_parity_en = 1; send(8'h42, 1, 1);
    req = "R11 keep clean"; send(8'h24, 0, 1);
    cfg_parity_en = 0; cfg_drop_err = 0;

    req = "R9 abort"; push(0, 16); push(1, 48); cfg_rx_off = 1; push(0, 48);
    push(1, 200);
    req = "R9 off whole frame"; send(8'h99, 0, 1);
    cfg_rx_off = 0;
    req = "R9 back on"; send(8'h66, 0, 1);

    req = "R10 hold"; cfg_hold_on_tx = 1; tx_active = 1; send(8'h11, 0, 1);
    req = "R10 hold mid frame"; tx_active = 0; push(0, 16); push(1, 32);
    tx_active = 1; push(1, 200);
    req = "R10 gating off"; cfg_hold_on_tx = 0; send(8'hEE, 0, 1);
    tx_active = 0;
    req = "R10 released"; cfg_hold_on_tx = 1; send(8'h7E, 0, 1);

    push(1, 8);
    summary();
    $finish;
  end
endmodule